// File: doc/BRIEF.md
# Character and Icon Display Command Decoder

This block sits behind the host port of a small dot-matrix display controller. The panel shows two rows of 5x7 characters and two rows of icon dots. Each accepted byte is either a command or a display byte, as a flag beside it says. The block turns these bytes into writes to three stores, all at the current 6-bit address:

- the code/icon-dot memory,
- the per-character blink flags,
- the icon blink plane.

It also holds every mode setting the display pipeline reads.

The address pointer runs through four windows of twelve entries, with unusable gaps between them. The address-increment command can first blank a character and/or clear its blink flag. A stop command puts the device into standby, and any later byte with bit 0 set wakes it and is executed. A busy flag tells the host how long to wait before sending the next byte.

Top module: `lcdc_top`

## Requirements
- R1: After reset these are all 0: the pointer, option bits, divider select, bank, display enable, icon-only, serial-output enable, blink pattern, line select, icon-blink mode, standby, busy and all write strobes. `contrast` equals `strap`. Display memory is not cleared.
- R2: The command `11aaaaaa` loads the pointer with `aaaaaa`. If the low nibble of that value is 12 to 15, the pointer becomes 0.
- R3: A pointer step goes from n to n+1 inside a window. It goes from 11 to 16, from 27 to 32, from 43 to 48, and from 59 to 0.
- R4: A byte with `is_cmd`=0 (icon-blink mode off) is written to the code memory at the current pointer. `dat_we` pulses in the cycle after acceptance, with `wr_addr` set to the old pointer. The pointer steps in the same edge.
- R5: `1011xxab` sets the option bits to `ab`. The command `100x101x` steps the pointer. Before it does, option bit 0 set writes BLANK_CODE (default 0x20) to the code memory at the old address. Option bit 1 set writes 0 to the blink flag there.
- R6: `000x01bx` writes b (bit 1) to the character blink flag at the pointer, then steps the pointer.
- R7: `100x001b` counts a 3-bit counter up (b=1) or down (b=0), wrapping 7 to 0 and 0 to 7. `contrast` equals the counter plus the 2-bit `strap`.
- R8: `100x110b` sets icon-blink mode to b. In that mode a display byte goes to the icon blink plane (bits 4..0) when the pointer is 32 or above. It is not written anywhere when the pointer is below 32. The pointer steps in both cases.
- R9: These commands set a mode and leave the pointer alone:
  - `100d4100d0`: display enable = d0, icon-only = d4
  - `100x000b`: bank = b
  - `100x011b`: serial-output enable = b
  - `100x111b`: blink pattern = b
  - `1010xxff`: divider select = ff
  - `011xxxll`: line select = ll
- R10: `100x0100` sets standby and clears display enable and icon-only.
- R11: In standby, a byte with bit 0 clear has no effect at all: no write, no pointer change, no mode change, no busy. A byte with bit 0 set clears standby and is executed as usual.
- R12: `busy` is high for exactly BUSY_CYC (default 10) cycles after each accepted byte. A new byte restarts the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_vld | input | 1 | One-cycle strobe: byte present |
| is_cmd | input | 1 | 1 = command byte, 0 = display byte |
| byte_in | input | 8 | Command or display byte |
| strap | input | 2 | Contrast stage offset |
| wr_addr | output | 6 | Address for all three write ports |
| dat_we | output | 1 | Code/icon-dot memory write strobe |
| dat_wdata | output | 8 | Code/icon-dot write data |
| cbl_we | output | 1 | Character blink flag write strobe |
| cbl_wdata | output | 1 | Character blink flag value |
| ibl_we | output | 1 | Icon blink plane write strobe |
| ibl_wdata | output | 5 | Icon blink dots |
| ptr | output | 6 | Address pointer |
| opt | output | 2 | Increment side-action bits |
| div_sel | output | 2 | Source clock divider select |
| bank | output | 1 | Character bank shown in short-duty mode |
| disp_on | output | 1 | Display enable |
| icon_only | output | 1 | Show icons only |
| so_en | output | 1 | Serial output driver enable |
| blink_pat | output | 1 | Character blink pattern |
| line_sel | output | 2 | Icon row placement |
| iblk_mode | output | 1 | Display bytes go to the icon blink plane |
| contrast | output | 4 | Contrast stage |
| standby | output | 1 | Standby active |
| busy | output | 1 | Host must wait |

## Verification
Some properties are checked on every cycle:
- the pointer never sits in a gap;
- icon-blink writes only target the icon half;
- the contrast stays within its strap window;
- every accepted byte raises busy;
- a stop command lands in standby with the display off;
- a sleeping device ignores bytes with bit 0 clear.

Other behaviour is only shown by the bench scenarios, where a behavioural model is compared every clock:
- the exact window-to-window step order and the 59-to-0 wrap;
- the blank and blink-clear side actions of the increment command;
- the contrast wrap in both directions;
- the bit 0 wake that also executes its byte.

// File: rtl/lcdc_pkg.sv
package lcdc_pkg;
  localparam int AW      = 6;
  localparam int WIN_LEN = 12;
  localparam int WIN_CNT = 4;

  typedef enum logic [3:0] {
    OP_NONE, OP_DATA, OP_LPA, OP_LOT, OP_SF, OP_BANK, OP_CONT, OP_STOP,
    OP_SOE, OP_DISP, OP_AINC, OP_ABB, OP_BPC, OP_CHB, OP_LINE
  } op_e;

  function automatic logic [AW-1:0] ptr_step(input logic [AW-1:0] p);
    logic [AW-1:0] r;
    if (p[3:0] == 4'(WIN_LEN - 1)) begin
      if (p[5:4] == 2'(WIN_CNT - 1)) r = '0;
      else                           r = {p[5:4] + 2'd1, 4'h0};
    end else begin
      r = p + 6'd1;
    end
    return r;
  endfunction

  function automatic logic [AW-1:0] ptr_clip(input logic [AW-1:0] a);
    return (a[3:0] >= 4'(WIN_LEN)) ? '0 : a;
  endfunction
endpackage

// File: rtl/lcdc_decode.sv
module lcdc_decode
  import lcdc_pkg::*;
(
  input  logic       is_cmd,
  input  logic [7:0] byte_in,
  output op_e        op
);
  always_comb begin
    op = OP_NONE;
    if (!is_cmd) begin
      op = OP_DATA;
    end else begin
      casez (byte_in)
        8'b11??????: op = OP_LPA;
        8'b1011????: op = OP_LOT;
        8'b1010????: op = OP_SF;
        8'b100?000?: op = OP_BANK;
        8'b100?001?: op = OP_CONT;
        8'b100?0100: op = OP_STOP;
        8'b100?011?: op = OP_SOE;
        8'b100?100?: op = OP_DISP;
        8'b100?101?: op = OP_AINC;
        8'b100?110?: op = OP_ABB;
        8'b100?111?: op = OP_BPC;
        8'b000?01??: op = OP_CHB;
        8'b011?????: op = OP_LINE;
        default:     op = OP_NONE;
      endcase
    end
  end
endmodule

// File: rtl/lcdc_ptr.sv
module lcdc_ptr
  import lcdc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          step,
  output logic [AW-1:0] ptr
);
  logic [AW-1:0] ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (load)      ptr_d = ptr_clip(load_val);
    else if (step) ptr_d = ptr_step(ptr_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            ptr_q <= '0;
    else if (load || step) ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;
endmodule

// File: rtl/lcdc_busy.sv
module lcdc_busy #(
  parameter int BUSY_CYC = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(BUSY_CYC + 1);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (start)              cnt_d = CW'(BUSY_CYC);
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/lcdc_top.sv
module lcdc_top
  import lcdc_pkg::*;
#(
  parameter logic [7:0] BLANK_CODE = 8'h20,
  parameter int         BUSY_CYC   = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       byte_vld,
  input  logic       is_cmd,
  input  logic [7:0] byte_in,
  input  logic [1:0] strap,
  output logic [5:0] wr_addr,
  output logic       dat_we,
  output logic [7:0] dat_wdata,
  output logic       cbl_we,
  output logic       cbl_wdata,
  output logic       ibl_we,
  output logic [4:0] ibl_wdata,
  output logic [5:0] ptr,
  output logic [1:0] opt,
  output logic [1:0] div_sel,
  output logic       bank,
  output logic       disp_on,
  output logic       icon_only,
  output logic       so_en,
  output logic       blink_pat,
  output logic [1:0] line_sel,
  output logic       iblk_mode,
  output logic [3:0] contrast,
  output logic       standby,
  output logic       busy
);
  // reset: asserted at once, released after two clock edges
  logic [1:0] rs_q;
  logic       rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_q = rs_q[1];

  op_e  dec_op, op;
  logic acc;
  lcdc_decode u_dec (.is_cmd(is_cmd), .byte_in(byte_in), .op(dec_op));

  assign acc = byte_vld && (!standby || byte_in[0]);
  assign op  = acc ? dec_op : OP_NONE;

  logic ptr_ld, ptr_inc;
  lcdc_ptr u_ptr (.clk(clk), .rst_n(rst_q), .load(ptr_ld), .load_val(byte_in[5:0]),
                  .step(ptr_inc), .ptr(ptr));

  lcdc_busy #(.BUSY_CYC(BUSY_CYC)) u_busy (.clk(clk), .rst_n(rst_q), .start(acc), .busy(busy));

  logic [1:0] opt_d, div_d, line_d;
  logic       bank_d, disp_d, icon_d, soe_d, bpat_d, abb_d, stb_d;
  logic [2:0] cnt_q, cnt_d;
  logic       dwe_d, cwe_d, cwd_d, iwe_d;
  logic [7:0] dwd_d;

  always_comb begin
    opt_d = opt;   div_d = div_sel; line_d = line_sel; bank_d = bank;
    disp_d = disp_on; icon_d = icon_only; soe_d = so_en; bpat_d = blink_pat;
    abb_d = iblk_mode; stb_d = standby; cnt_d = cnt_q;
    ptr_ld = 1'b0; ptr_inc = 1'b0;
    dwe_d = 1'b0; dwd_d = byte_in; cwe_d = 1'b0; cwd_d = 1'b0; iwe_d = 1'b0;
    if (acc) stb_d = 1'b0;
    case (op)
      OP_DATA: begin
        ptr_inc = 1'b1;
        if (!iblk_mode) dwe_d = 1'b1;
        else if (ptr[5]) iwe_d = 1'b1;
      end
      OP_LPA:  ptr_ld = 1'b1;
      OP_LOT:  opt_d = byte_in[1:0];
      OP_SF:   div_d = byte_in[1:0];
      OP_BANK: bank_d = byte_in[0];
      OP_CONT: cnt_d = byte_in[0] ? cnt_q + 3'd1 : cnt_q - 3'd1;
      OP_STOP: begin stb_d = 1'b1; disp_d = 1'b0; icon_d = 1'b0; end
      OP_SOE:  soe_d = byte_in[0];
      OP_DISP: begin disp_d = byte_in[0]; icon_d = byte_in[4]; end
      OP_AINC: begin
        ptr_inc = 1'b1;
        if (opt[0]) begin dwe_d = 1'b1; dwd_d = BLANK_CODE; end
        if (opt[1]) begin cwe_d = 1'b1; cwd_d = 1'b0; end
      end
      OP_ABB:  abb_d = byte_in[0];
      OP_BPC:  bpat_d = byte_in[0];
      OP_CHB:  begin ptr_inc = 1'b1; cwe_d = 1'b1; cwd_d = byte_in[1]; end
      OP_LINE: line_d = byte_in[1:0];
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      opt <= '0; div_sel <= '0; line_sel <= '0; bank <= 1'b0;
      disp_on <= 1'b0; icon_only <= 1'b0; so_en <= 1'b0; blink_pat <= 1'b0;
      iblk_mode <= 1'b0; standby <= 1'b0; cnt_q <= '0;
      dat_we <= 1'b0; cbl_we <= 1'b0; ibl_we <= 1'b0;
      dat_wdata <= '0; cbl_wdata <= 1'b0; ibl_wdata <= '0; wr_addr <= '0;
    end else begin
      opt <= opt_d; div_sel <= div_d; line_sel <= line_d; bank <= bank_d;
      disp_on <= disp_d; icon_only <= icon_d; so_en <= soe_d; blink_pat <= bpat_d;
      iblk_mode <= abb_d; standby <= stb_d; cnt_q <= cnt_d;
      dat_we <= dwe_d; cbl_we <= cwe_d; ibl_we <= iwe_d;
      if (acc) begin
        wr_addr   <= ptr;
        dat_wdata <= dwd_d;
        cbl_wdata <= cwd_d;
        ibl_wdata <= byte_in[4:0];
      end
    end
  end

  assign contrast = {1'b0, cnt_q} + {2'b00, strap};
endmodule

// File: rtl/lcdc_chk.sv
module lcdc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       byte_vld,
  input logic       is_cmd,
  input logic [7:0] byte_in,
  input logic [1:0] strap,
  input logic [5:0] ptr,
  input logic [5:0] wr_addr,
  input logic       dat_we,
  input logic       cbl_we,
  input logic       ibl_we,
  input logic [3:0] contrast,
  input logic       disp_on,
  input logic       standby,
  input logic       busy
);
  // R2 R3
  ptr_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr[3:0] < 4'd12);

  // R8
  iblk_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ibl_we |-> wr_addr[5]);

  // R7
  contrast_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (contrast >= {2'b00, strap}) && (contrast <= {2'b00, strap} + 4'd7));

  // R12
  busy_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && (!standby || byte_in[0])) |=> busy);

  // R10
  stop_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && is_cmd && !standby && byte_in[7:5] == 3'b100 && byte_in[3:0] == 4'b0100)
    |=> (standby && !disp_on));

  // R11
  sleep_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (standby && byte_vld && !byte_in[0])
    |=> (!dat_we && !cbl_we && !ibl_we && $stable(ptr) && standby));
endmodule

bind lcdc_top lcdc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .is_cmd(is_cmd), .byte_in(byte_in),
  .strap(strap), .ptr(ptr), .wr_addr(wr_addr), .dat_we(dat_we), .cbl_we(cbl_we),
  .ibl_we(ibl_we), .contrast(contrast), .disp_on(disp_on), .standby(standby), .busy(busy)
);

// File: tb/lcdc_top_tb.sv
module lcdc_top_tb;
  localparam int CLK_NS = 10;

  logic clk = 1'b0;
  logic rst_n, byte_vld, is_cmd;
  logic [7:0] byte_in;
  logic [1:0] strap;
  logic [5:0] wr_addr, ptr;
  logic dat_we, cbl_we, cbl_wdata, ibl_we;
  logic [7:0] dat_wdata;
  logic [4:0] ibl_wdata;
  logic [1:0] opt, div_sel, line_sel;
  logic bank, disp_on, icon_only, so_en, blink_pat, iblk_mode, standby, busy;
  logic [3:0] contrast;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #(CLK_NS/2) clk = ~clk;

  lcdc_top u_dut (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .is_cmd(is_cmd), .byte_in(byte_in),
    .strap(strap), .wr_addr(wr_addr), .dat_we(dat_we), .dat_wdata(dat_wdata),
    .cbl_we(cbl_we), .cbl_wdata(cbl_wdata), .ibl_we(ibl_we), .ibl_wdata(ibl_wdata),
    .ptr(ptr), .opt(opt), .div_sel(div_sel), .bank(bank), .disp_on(disp_on),
    .icon_only(icon_only), .so_en(so_en), .blink_pat(blink_pat), .line_sel(line_sel),
    .iblk_mode(iblk_mode), .contrast(contrast), .standby(standby), .busy(busy)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_ptr, m_opt, m_div, m_line, m_bank, m_disp, m_icon, m_soe, m_bpat, m_abb, m_stb;
  int m_cnt, m_bc, m_dwe, m_dwd, m_cwe, m_cwd, m_iwe, m_iwd, m_addr;

  function automatic int next_addr(input int p);
    if (p % 16 == 11) return (p >= 48) ? 0 : (p / 16 + 1) * 16;
    return p + 1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ptr = 0; m_opt = 0; m_div = 0; m_line = 0; m_bank = 0; m_disp = 0; m_icon = 0;
      m_soe = 0; m_bpat = 0; m_abb = 0; m_stb = 0; m_cnt = 0; m_bc = 0;
      m_dwe = 0; m_cwe = 0; m_iwe = 0; m_dwd = 0; m_cwd = 0; m_iwd = 0; m_addr = 0;
    end else begin
      m_dwe = 0; m_cwe = 0; m_iwe = 0;
      if (m_bc > 0) m_bc--;
      if (byte_vld && (m_stb == 0 || byte_in[0])) begin
        int b;
        b = byte_in;
        m_stb = 0; m_bc = 10; m_addr = m_ptr;
        if (!is_cmd) begin
          if (m_abb == 0) begin m_dwe = 1; m_dwd = b; end
          else if (m_ptr >= 32) begin m_iwe = 1; m_iwd = b % 32; end
          m_ptr = next_addr(m_ptr);
        end else if (b >= 192) begin
          m_ptr = ((b % 64) % 16 >= 12) ? 0 : b % 64;
        end else if (b / 16 == 11) m_opt = b % 4;
        else if (b / 16 == 10) m_div = b % 4;
        else if (b / 32 == 3) m_line = b % 4;
        else if (b / 32 == 0 && (b / 4) % 4 == 1) begin
          m_cwe = 1; m_cwd = (b / 2) % 2; m_ptr = next_addr(m_ptr);
        end else if (b / 32 == 4) begin
          case ((b % 16) / 2)
            0: m_bank = b % 2;
            1: m_cnt = (b % 2) ? (m_cnt + 1) % 8 : (m_cnt + 7) % 8;
            2: if (b % 2 == 0) begin m_stb = 1; m_disp = 0; m_icon = 0; end
            3: m_soe = b % 2;
            4: begin m_disp = b % 2; m_icon = (b / 16) % 2; end
            5: begin
              if (m_opt % 2) begin m_dwe = 1; m_dwd = 8'h20; end
              if (m_opt / 2) begin m_cwe = 1; m_cwd = 0; end
              m_ptr = next_addr(m_ptr);
            end
            6: m_abb = b % 2;
            7: m_bpat = b % 2;
            default: ;
          endcase
        end
      end
    end
  end

  // every-clock comparison, sampled mid-cycle
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R3 ptr", ptr, m_ptr);
      chk("R4 dat_we", dat_we, m_dwe);
      if (m_dwe) begin chk("R4 dat_wdata", dat_wdata, m_dwd); chk("R4 wr_addr", wr_addr, m_addr); end
      chk("R6 cbl_we", cbl_we, m_cwe);
      if (m_cwe) begin chk("R6 cbl_wdata", cbl_wdata, m_cwd); chk("R6 wr_addr", wr_addr, m_addr); end
      chk("R8 ibl_we", ibl_we, m_iwe);
      if (m_iwe) begin chk("R8 ibl_wdata", ibl_wdata, m_iwd); chk("R8 wr_addr", wr_addr, m_addr); end
      chk("R5 opt", opt, m_opt);
      chk("R9 div_sel", div_sel, m_div);
      chk("R9 line_sel", line_sel, m_line);
      chk("R9 bank", bank, m_bank);
      chk("R9 disp_on", disp_on, m_disp);
      chk("R9 icon_only", icon_only, m_icon);
      chk("R9 so_en", so_en, m_soe);
      chk("R9 blink_pat", blink_pat, m_bpat);
      chk("R8 iblk_mode", iblk_mode, m_abb);
      chk("R7 contrast", contrast, m_cnt + strap);
      chk("R10 standby", standby, m_stb);
      chk("R12 busy", busy, m_bc != 0);
    end
  end

  // last-write capture for targeted checks
  int last_dw, last_da, last_cw, last_ca, n_iw;
  always @(negedge clk) begin
    if (dat_we) begin last_dw = dat_wdata; last_da = wr_addr; end
    if (cbl_we) begin last_cw = cbl_wdata; last_ca = wr_addr; end
    if (ibl_we) n_iw++;
  end

  task automatic send(input bit c, input logic [7:0] b, input int gap);
    @(negedge clk);
    byte_vld = 1'b1; is_cmd = c; byte_in = b;
    @(negedge clk);
    byte_vld = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; byte_vld = 1'b0; is_cmd = 1'b0; byte_in = 8'h00; strap = 2'd2;
    n_iw = 0; last_dw = -1; last_da = -1; last_cw = -1; last_ca = -1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 ptr", ptr, 0); chk("R1 contrast", contrast, 2);
    chk("R1 busy", busy, 0); chk("R1 standby", standby, 0); chk("R1 disp_on", disp_on, 0);

    // R4 display bytes
    send(0, 8'h41, 11); send(0, 8'h42, 11);
    chk("R4 ptr after two bytes", ptr, 2);
    chk("R4 last code", last_dw, 8'h42);

    // R2 pointer loads including gap addresses
    send(1, 8'hC0 | 8'h0B, 11); send(0, 8'h43, 11);
    chk("R3 11 to 16", ptr, 16);
    send(1, 8'hC0 | 8'h2D, 11);
    chk("R2 gap load", ptr, 0);
    send(1, 8'hC0 | 8'h3B, 11); send(1, 8'h8A, 11);
    chk("R3 59 wraps", ptr, 0);
    send(1, 8'hC0 | 8'h1B, 11); send(1, 8'h9B, 11);
    chk("R3 27 to 32", ptr, 32);

    // R5 side actions on increment
    send(1, 8'hB3, 11); send(1, 8'hC5, 11); send(1, 8'h8A, 11);
    chk("R5 blank code", last_dw, 8'h20); chk("R5 blank addr", last_da, 5);
    chk("R5 blink clear", last_cw, 0); chk("R5 ptr", ptr, 6);
    send(1, 8'hB0, 11);

    // R6 character blink flag
    send(1, 8'h06, 11);
    chk("R6 flag", last_cw, 1); chk("R6 addr", last_ca, 6); chk("R6 ptr", ptr, 7);

    // R7 contrast both wraps
    send(1, 8'h82, 11);
    chk("R7 down wrap", contrast, 9);
    send(1, 8'h83, 11); send(1, 8'h93, 11);
    chk("R7 up wrap", contrast, 3);

    // R8 icon blink plane
    send(1, 8'h8D, 11); send(1, 8'hE0, 11); send(0, 8'h1F, 11);
    chk("R8 icon write", n_iw, 1);
    send(1, 8'hC3, 11); send(0, 8'h15, 11);
    chk("R8 low half ignored", n_iw, 1); chk("R8 ptr steps", ptr, 4);
    send(1, 8'h8C, 11);

    // R9 mode commands
    send(1, 8'h99, 11); send(1, 8'h81, 11); send(1, 8'h87, 11);
    send(1, 8'h8F, 11); send(1, 8'hA2, 11); send(1, 8'h62, 11);
    chk("R9 icon_only", icon_only, 1); chk("R9 line", line_sel, 2); chk("R9 ptr kept", ptr, 4);

    // R12 back-to-back bytes restart busy
    send(0, 8'h30, 3); send(0, 8'h31, 0);
    repeat (8) @(negedge clk);
    chk("R12 still busy", busy, 1);
    repeat (3) @(negedge clk);
    chk("R12 idle", busy, 0);

    // R10 stop, R11 wake rules
    send(1, 8'h84, 11);
    chk("R10 standby", standby, 1); chk("R10 disp off", disp_on, 0);
    send(0, 8'h40, 11); send(1, 8'h82, 11);
    chk("R11 ptr held", ptr, 6); chk("R11 contrast held", contrast, 3); chk("R11 no busy", busy, 0);
    send(0, 8'h41, 11);
    chk("R11 woke", standby, 0); chk("R11 executed", last_dw, 8'h41); chk("R11 ptr", ptr, 7);

    // reset keeps nothing but memory
    send(1, 8'hC9, 2);
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; repeat (4) @(negedge clk);
    chk("R1 ptr after reset", ptr, 0); chk("R1 iblk_mode", iblk_mode, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule